// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

The block forms the Montgomery product of two K-bit operands: S = X·Y·2^(-K) mod M, for an odd modulus M with its top bit set (2^(K-1) < M < 2^K). The multiplier X is consumed one bit per outer pass. The multiplicand Y, the modulus M and the running sum S are handled one W-bit word per clock. The operands and the partial sum live in internal word memories with registered read data. Each memory read is issued one cycle before the word is needed, so the engine never waits for a read.

A host loads X, Y and M word by word while the block is idle and then pulses `start`. In each outer pass the engine first decides whether to add M. It bases this on the parity of the first sum word. It then walks the words, propagating a carry, and writes each word back one position lower. That write shifts S right by one bit across the word boundaries. When the last pass completes, `done` pulses for one cycle and `done_flag` stays set. S can then be read a word at a time through `rd_addr`/`rd_data`, with its one overflow bit on `rd_top`.

The result is only partially reduced. It lies in [0, 2M) and needs K+1 bits, so the bit at position E·W, where E = ceil(K/W), is kept in a separate register.

Top module: `mont_word_mul`

## Requirements
- R1: After a run with odd M, 2^(K-1) < M < 2^K, and X, Y < M, the value S = (word E-1 … word 0) + rd_top·2^(E·W) satisfies S ≡ X·Y·2^(-K) (mod M) and 0 ≤ S < 2M.
- R2: While idle, a cycle with ld_en high writes ld_data into word ld_addr of the operand chosen by ld_sel (0 = X, 1 = Y, 2 = M, 3 = none). Word 0 is the least significant. Load cycles while busy have no effect on the result.
- R3: A start pulse while idle raises busy in the next cycle. Busy then stays high for exactly 1 + K·(E+1) cycles.
- R4: A start pulse while busy is ignored. The run in progress neither restarts nor changes its length or result.
- R5: done is high for exactly one cycle, in the first cycle that busy is low after a run. done_flag rises together with done, stays high while idle, and is cleared in the cycle after an accepted start.
- R6: While idle, rd_data shows word rd_addr of S one cycle after rd_addr is presented. rd_top holds bit E·W of S.
- R7: After reset, busy, done and done_flag are all 0.
- R8: Runs issued back to back are independent: every run starts its sum at zero, whatever the previous result was.
- R9: If X = 0 or Y = 0, the result is exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| ld_en | input | 1 | Operand word write strobe |
| ld_sel | input | 2 | Operand select: 0 X, 1 Y, 2 M, 3 none |
| ld_addr | input | 3 | Word index of the write (clog2(E)) |
| ld_data | input | 8 | Word written (W) |
| rd_addr | input | 3 | Word index of S to read |
| rd_data | output | 8 | Word of S, one cycle after rd_addr |
| rd_top | output | 1 | Bit E·W of S |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion status |

## Verification
The products are tried with several operand patterns, and each one separates a different kind of fault:
- A zero multiplier and a zero multiplicand give an exact-zero result. This catches any spurious modulus addition or stale sum.
- X = Y = 1 isolates the division by 2^K. Near-modulus operands (M−1) drive the carries, and with them the overflow bit, to their limits.
- A modulus of 2^(K-1)+1 stresses the parity decision in almost every pass.
- One run receives a mid-run start and a mid-run Y overwrite, and its result and length must stay unchanged.
- Consecutive runs with different moduli reveal any sum state carried from one run to the next.

// File: rtl/mmw_pkg.sv
package mmw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_RUN  = 2'd2,
      ST_TAIL = 2'd3
   } mmw_state_e;

   localparam int unsigned N_OPS = 3;  // X, Y, M operand stores

endpackage

// File: rtl/mmw_wordram.sv
module mmw_wordram #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 3
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   if (DEPTH > (1 << AW)) begin : g_bad_depth
      $error("mmw_wordram: DEPTH exceeds address space");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/mmw_pe.sv
module mmw_pe #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         x_load,
   input  logic         x_in,
   input  logic         run,
   input  logic         first_word,
   input  logic         first_bit,
   input  logic         tail,
   input  logic [W-1:0] s_in,
   input  logic [W-1:0] y_in,
   input  logic [W-1:0] m_in,
   output logic [W-1:0] wr_data,
   output logic         top_out
);

   logic           x_q;      // local copy of the current multiplier bit
   logic           q_q;      // add-modulus decision for this pass
   logic [1:0]     c_q;      // word carry, at most 2
   logic [W-2:0]   held_q;   // upper bits of the previous new word
   logic           top_q;    // bit E*W of the sum
   logic [W-1:0]   s_eff, xy;
   logic [W+1:0]   base, acc;
   logic [1:0]     hi;
   logic           q_now;

   always_comb begin
      s_eff   = first_bit ? '0 : s_in;
      xy      = x_q ? y_in : '0;
      base    = {2'b00, xy} + {2'b00, s_eff} + (first_word ? '0 : {{W{1'b0}}, c_q});
      q_now   = first_word ? base[0] : q_q;
      acc     = base + (q_now ? {2'b00, m_in} : '0);
      hi      = c_q + {1'b0, top_q};
      wr_data = tail ? {hi[0], held_q} : {acc[0], held_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= 1'b0;
         q_q    <= 1'b0;
         c_q    <= '0;
         held_q <= '0;
         top_q  <= 1'b0;
      end else begin
         if (x_load) x_q <= x_in;
         if (run) begin
            held_q <= acc[W-1:1];
            c_q    <= acc[W+1:W];
            if (first_word) q_q <= base[0];
         end
         if (clr)       top_q <= 1'b0;
         else if (tail) top_q <= hi[1];
      end
   end

   assign top_out = top_q;

   // R1
   low_word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && first_word) |-> (acc[0] == 1'b0));

   // R1
   carry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> (c_q <= 2'd2));

endmodule

// File: rtl/mmw_seq.sv
module mmw_seq
   import mmw_pkg::*;
#(
   parameter int unsigned K  = 64,
   parameter int unsigned E  = 8,
   parameter int unsigned LE = 3,
   parameter int unsigned LW = 3,
   parameter int unsigned BW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          done_flag,
   output logic          start_ok,
   output logic          run,
   output logic          tail,
   output logic          first_word,
   output logic          first_bit,
   output logic          x_load,
   output logic [LW-1:0] x_pos,
   output logic [LE-1:0] x_addr,
   output logic [LE-1:0] eng_raddr,
   output logic [LE-1:0] s_waddr,
   output logic          s_we
);

   localparam logic [LE-1:0] LASTW = LE'(E - 1);
   localparam logic [BW-1:0] LASTB = BW'(K - 1);
   localparam int unsigned   LAT   = 1 + K * (E + 1);

   mmw_state_e    state;
   logic [LE-1:0] j_q;
   logic [BW-1:0] b_q;

   always_comb begin
      busy       = (state != ST_IDLE);
      start_ok   = (state == ST_IDLE) && start;
      run        = (state == ST_RUN);
      tail       = (state == ST_TAIL);
      first_word = run && (j_q == '0);
      first_bit  = (b_q == '0);
      x_load     = (state == ST_PRE) || tail;
      x_pos      = (state == ST_PRE) ? '0 : LW'(b_q + 1'b1);
      x_addr     = busy ? LE'((b_q + 1'b1) >> LW) : '0;
      eng_raddr  = (run && (j_q != LASTW)) ? LE'(j_q + 1'b1) : '0;
      s_we       = (run && (j_q != '0)) || tail;
      s_waddr    = tail ? LASTW : LE'(j_q - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         j_q       <= '0;
         b_q       <= '0;
         done      <= 1'b0;
         done_flag <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state     <= ST_PRE;
               j_q       <= '0;
               b_q       <= '0;
               done_flag <= 1'b0;
            end
            ST_PRE: begin
               state <= ST_RUN;
               j_q   <= '0;
            end
            ST_RUN: begin
               if (j_q == LASTW) state <= ST_TAIL;
               else              j_q   <= j_q + 1'b1;
            end
            ST_TAIL: begin
               j_q <= '0;
               if (b_q == LASTB) begin
                  state     <= ST_IDLE;
                  done      <= 1'b1;
                  done_flag <= 1'b1;
               end else begin
                  b_q   <= b_q + 1'b1;
                  state <= ST_RUN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // run-length counter used by the latency check
   logic [31:0] cyc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc_q <= '0;
      else if (start_ok) cyc_q <= '0;
      else if (busy)     cyc_q <= cyc_q + 1'b1;
   end

   // R3
   run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_q == LAT));

   // R4
   restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (state != ST_PRE));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (!done_flag && busy));

endmodule

// File: rtl/mont_word_mul.sv
module mont_word_mul
   import mmw_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter int unsigned K = 64,
   localparam int unsigned E  = (K + W - 1) / W,
   localparam int unsigned LE = (E > 1) ? $clog2(E) : 1,
   localparam int unsigned LW = (W > 1) ? $clog2(W) : 1,
   localparam int unsigned BW = $clog2(K + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ld_en,
   input  logic [1:0]    ld_sel,
   input  logic [LE-1:0] ld_addr,
   input  logic [W-1:0]  ld_data,
   input  logic [LE-1:0] rd_addr,
   output logic [W-1:0]  rd_data,
   output logic          rd_top,
   output logic          busy,
   output logic          done,
   output logic          done_flag
);

   if (W < 2 || (1 << LW) != W) begin : g_bad_w
      $error("mont_word_mul: W must be a power of two, at least 2");
   end
   if (E < 2) begin : g_bad_e
      $error("mont_word_mul: K must span at least two words");
   end

   logic          start_ok, run, tail, first_word, first_bit, x_load, s_we;
   logic [LW-1:0] x_pos;
   logic [LE-1:0] x_addr, eng_raddr, s_waddr, s_raddr;
   logic [W-1:0]  op_rd [N_OPS];
   logic [W-1:0]  s_wdata, s_rd;

   mmw_seq #(.K(K), .E(E), .LE(LE), .LW(LW), .BW(BW)) u_seq (
      .clk, .rst_n, .start, .busy, .done, .done_flag, .start_ok,
      .run, .tail, .first_word, .first_bit, .x_load, .x_pos,
      .x_addr, .eng_raddr, .s_waddr, .s_we
   );

   for (genvar g = 0; g < N_OPS; g++) begin : g_op
      logic [LE-1:0] ra;
      if (g == 0) begin : g_xport
         assign ra = x_addr;
      end else begin : g_wport
         assign ra = eng_raddr;
      end
      mmw_wordram #(.WIDTH(W), .DEPTH(E), .AW(LE)) u_ram (
         .clk,
         .we    (ld_en && !busy && (ld_sel == 2'(g))),
         .waddr (ld_addr),
         .wdata (ld_data),
         .raddr (ra),
         .rdata (op_rd[g])
      );
   end

   assign s_raddr = busy ? eng_raddr : rd_addr;

   mmw_wordram #(.WIDTH(W), .DEPTH(E), .AW(LE)) u_sram (
      .clk,
      .we    (s_we),
      .waddr (s_waddr),
      .wdata (s_wdata),
      .raddr (s_raddr),
      .rdata (s_rd)
   );

   mmw_pe #(.W(W)) u_pe (
      .clk, .rst_n,
      .clr        (start_ok),
      .x_load,
      .x_in       (op_rd[0][x_pos]),
      .run, .first_word, .first_bit, .tail,
      .s_in       (s_rd),
      .y_in       (op_rd[1]),
      .m_in       (op_rd[2]),
      .wr_data    (s_wdata),
      .top_out    (rd_top)
   );

   assign rd_data = s_rd;

   // R1
   sum_port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_we |-> (s_waddr != s_raddr));

endmodule

// File: tb/mont_word_mul_bench.sv
module mont_word_mul_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W   = 8;
   localparam int K   = 64;
   localparam int E   = K / W;
   localparam int LE  = 3;
   localparam int LAT = 1 + K * (E + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          ld_en = 1'b0;
   logic [1:0]    ld_sel = '0;
   logic [LE-1:0] ld_addr = '0;
   logic [W-1:0]  ld_data = '0;
   logic [LE-1:0] rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic          rd_top, busy, done, done_flag;

   mont_word_mul #(.W(W), .K(K)) u_mont_word_mul (
      .clk, .rst_n, .start, .ld_en, .ld_sel, .ld_addr, .ld_data,
      .rd_addr, .rd_data, .rd_top, .busy, .done, .done_flag
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int rd_cnt = 0;

   typedef struct {
      logic [K:0] lo;
      logic [K:0] hi;
      logic       exact;
      string      tag;
   } exp_t;
   exp_t sb [$];

   task automatic check(input bit ok, input string req, input logic [K:0] act,
                        input logic [K:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // modular halving K times: value z with z*2^K == x*y (mod m)
   function automatic logic [K:0] ref_mm(input logic [K-1:0] x, y, m);
      logic [2*K-1:0] p;
      logic [K:0]     r;
      p = {{K{1'b0}}, x} * {{K{1'b0}}, y};
      p = p % {{K{1'b0}}, m};
      r = {1'b0, p[K-1:0]};
      for (int i = 0; i < K; i++) begin
         if (r[0]) r = r + {1'b0, m};
         r = r >> 1;
      end
      return r;
   endfunction

   task automatic load_op(input logic [1:0] sel, input logic [K-1:0] v);
      for (int w = 0; w < E; w++) begin
         @(negedge clk);
         ld_en   = 1'b1;
         ld_sel  = sel;
         ld_addr = LE'(w);
         ld_data = v[w*W +: W];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_op(input logic [K-1:0] x, y, m, input bit exact,
                         input string tag, input bit disturb);
      exp_t e;
      int   cyc;
      int   target;
      logic [K:0] z;
      load_op(2'd0, x);
      load_op(2'd1, y);
      load_op(2'd2, m);
      z       = ref_mm(x, y, m);
      e.lo    = z;
      e.hi    = z + {1'b0, m};
      e.exact = exact;
      e.tag   = tag;
      sb.push_back(e);
      target = rd_cnt + 1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3 busy after start", {64'b0, busy}, 65'd1);
      check(done_flag == 1'b0, "R5 flag cleared by start", {64'b0, done_flag}, 65'd0);
      cyc = 0;
      while (busy && cyc < LAT + 10) begin
         cyc++;
         if (disturb && cyc == 20) begin
            start   = 1'b1;          // R4: ignored start
            ld_en   = 1'b1;          // R2: ignored load into Y
            ld_sel  = 2'd1;
            ld_addr = '0;
            ld_data = ~y[W-1:0];
         end else if (disturb && cyc == 21) begin
            start = 1'b0;
            ld_en = 1'b0;
         end
         @(negedge clk);
      end
      check(cyc == LAT, "R3 run length", 65'(cyc), 65'(LAT));
      check(done == 1'b1, "R5 done with busy low", {64'b0, done}, 65'd1);
      check(done_flag == 1'b1, "R5 flag set", {64'b0, done_flag}, 65'd1);
      wait (rd_cnt == target);
      @(negedge clk);
      check(done_flag == 1'b1 && done == 1'b0, "R5 flag sticky, done pulse",
            {63'b0, done_flag, done}, 65'd2);
   endtask

   // monitor: reads S after each completion and scores it
   initial begin : monitor
      logic [K:0] got;
      exp_t e;
      forever begin
         @(negedge clk);
         if (done) begin
            for (int w = 0; w < E; w++) begin
               rd_addr = LE'(w);
               @(negedge clk);
               got[w*W +: W] = rd_data;   // R6: one-cycle read latency
            end
            got[K] = rd_top;
            if (sb.size() == 0) begin
               check(1'b0, "R1 unexpected result", got, '0);
            end else begin
               e = sb.pop_front();
               if (e.exact)
                  check(got == e.lo, {"R9 ", e.tag}, got, e.lo);
               else
                  check(got == e.lo || got == e.hi, {"R1 R6 ", e.tag}, got, e.lo);
            end
            rd_cnt++;
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   localparam logic [K-1:0] M1 = 64'hF123_4567_89AB_CDEF;
   localparam logic [K-1:0] M2 = 64'h8000_0000_0000_0001;

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7
      check(busy == 1'b0, "R7 busy reset", {64'b0, busy}, 65'd0);
      check(done == 1'b0, "R7 done reset", {64'b0, done}, 65'd0);
      check(done_flag == 1'b0, "R7 flag reset", {64'b0, done_flag}, 65'd0);

      run_op(64'h0, 64'h1234_5678_9ABC_DEF0, M1, 1'b1, "x zero", 1'b0);
      run_op(64'h0FED_CBA9_8765_4321, 64'h0, M1, 1'b1, "y zero", 1'b0);
      run_op(64'h1, 64'h1, M1, 1'b0, "unit operands", 1'b0);
      run_op(64'h0123_4567_89AB_CDEE, 64'hDEAD_BEEF_0BAD_F00D, M1, 1'b0,
             "R2 R4 mid-run start and load", 1'b1);
      run_op(M1 - 1, M1 - 1, M1, 1'b0, "near modulus", 1'b0);
      run_op(M2 - 1, 64'h7FFF_FFFF_FFFF_FFFF, M2, 1'b0, "R8 small modulus", 1'b0);
      run_op(64'h2, 64'h3, M2, 1'b0, "R8 back to back", 1'b0);

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R1 all results seen", 65'(sb.size()), 65'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule